// File: doc/BRIEF.md
# Banked Bit-Addressable Scratch RAM

A 128-byte data store for an 8-bit controller core. The store has three ways in. A byte port reads and writes any byte by its 7-bit address. A register port takes a 3-bit register number and resolves it against the active bank of eight registers; the four banks occupy the lowest 32 bytes. A bit port takes an 8-bit bit address and can read, set or clear a single bit.

Bit addresses below 80H fold onto the sixteen bytes starting at 20H. Bit addresses of 80H and above go out through a side port to the bit-addressable special function registers, which sit at byte addresses whose low three bits are zero. Set and clear are single-cycle read-modify-write operations. All reads are registered. The array keeps its contents through reset, so the core can rely on data surviving a soft restart.

The core drives the bank select from its status word. The store samples that value on every clock. Reset forces the sampled copy to bank 0.

Top module: `bitram`

## Requirements
- R1: A byte-port read returns the addressed byte on `byte_rdata` one clock after `byte_rd`. A read and a write to the same byte in one cycle return the old value. `byte_rdata` holds its value in cycles without `byte_rd`.
- R2: A register-port access uses RAM address 8*bank + `reg_num`. Here bank is the `bank_sel` value sampled at the previous clock edge: bank_sel 00/01/10/11 give banks 0/1/2/3 at 00H–07H, 08H–0FH, 10H–17H and 18H–1FH. `reg_rdata` follows one clock after `reg_rd`.
- R3: Reset clears `byte_rdata`, `reg_rdata` and `bit_rdata` and makes bank 0 active for the first clock after release. Reset leaves the RAM contents unchanged.
- R4: A bit address a below 80H selects bit a[2:0] of RAM byte 20H + a[6:3]; for example, bit 08H is bit 0 of byte 21H. `bit_rdata` follows one clock after `bit_rd`. The same bytes stay readable and writable through the byte port.
- R5: `bit_set` makes the addressed bit 1 and `bit_clr` makes it 0, completing in one clock. The other seven bits of the byte are kept. When both are high, set wins.
- R6: For a bit address a of 80H or above, `sfr_addr` = a with bits [2:0] cleared. A set or clear raises `sfr_wr` for that cycle, with `sfr_wdata` equal to `sfr_rdata` with bit a[2:0] changed. Such an operation leaves the RAM untouched. `sfr_wr` stays low for RAM bit addresses and when no set or clear is requested.
- R7: A bit read at address 80H or above returns bit a[2:0] of `sfr_rdata`, registered one clock later.
- R8: When writes from several ports land on the same byte in one cycle, the byte port wins over the register port, and the register port wins over the bit port. Writes to different bytes in the same cycle all take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_sel | input | 2 | Register bank select |
| byte_rd | input | 1 | Byte read strobe |
| byte_wr | input | 1 | Byte write strobe |
| byte_addr | input | 7 | Byte address |
| byte_wdata | input | 8 | Byte write data |
| byte_rdata | output | 8 | Registered byte read data |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_num | input | 3 | Register number within the bank |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered register read data |
| bit_rd | input | 1 | Bit read strobe |
| bit_set | input | 1 | Bit set strobe |
| bit_clr | input | 1 | Bit clear strobe |
| bit_addr | input | 8 | Bit address |
| bit_rdata | output | 1 | Registered bit read data |
| sfr_addr | output | 8 | Special function register byte address |
| sfr_rdata | input | 8 | Special function register current value |
| sfr_wr | output | 1 | Special function register write strobe |
| sfr_wdata | output | 8 | Special function register write data |

## Verification
The bench builds the block with its default parameters: 128 bytes, four banks of eight registers, and a bit segment at 20H. At that size every byte, every register of every bank and all 256 bit addresses can be swept. A bench model of the special function registers answers on the side port, so the bit sweep also covers the upper half of the bit space. Every RAM bit is set or cleared in turn, and the whole array is read back to show that neighbouring bits and bytes are untouched. Same-byte write collisions, the one-cycle lag of the bank select, and retention across a second reset are each driven as directed cases.

// File: rtl/bitram.sv
module bitram #(
  parameter int DEPTH    = 128,
  parameter int BANKS    = 4,
  parameter int REGS     = 8,
  parameter int BIT_BASE = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bank_sel,
  input  logic       byte_rd,
  input  logic       byte_wr,
  input  logic [6:0] byte_addr,
  input  logic [7:0] byte_wdata,
  output logic [7:0] byte_rdata,
  input  logic       reg_rd,
  input  logic       reg_wr,
  input  logic [2:0] reg_num,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       bit_rd,
  input  logic       bit_set,
  input  logic       bit_clr,
  input  logic [7:0] bit_addr,
  output logic       bit_rdata,
  output logic [7:0] sfr_addr,
  input  logic [7:0] sfr_rdata,
  output logic       sfr_wr,
  output logic [7:0] sfr_wdata
);
  localparam int AW = $clog2(DEPTH);
  localparam int BW = $clog2(BANKS);
  localparam int RW = $clog2(REGS);

  logic [7:0]    mem [DEPTH];
  logic [BW-1:0] bank_q;

  wire [AW-1:0] reg_idx  = AW'({bank_q, reg_num[RW-1:0]});
  wire          bit_wr   = bit_set | bit_clr;
  wire          bit_sfr  = bit_addr[7];
  wire [AW-1:0] bit_byte = AW'(BIT_BASE) + AW'(bit_addr[6:3]);
  wire [7:0]    bit_old  = bit_sfr ? sfr_rdata : mem[bit_byte];
  wire [7:0]    bit_mask = 8'b1 << bit_addr[2:0];
  wire [7:0]    bit_new  = bit_set ? (bit_old | bit_mask) : (bit_old & ~bit_mask);

  assign sfr_addr  = {bit_addr[7:3], 3'b000};
  assign sfr_wr    = bit_wr & bit_sfr;
  assign sfr_wdata = bit_new;

  // later assignments win: byte over register over bit
  always_ff @(posedge clk) begin
    if (bit_wr && !bit_sfr) mem[bit_byte] <= bit_new;
    if (reg_wr)             mem[reg_idx]  <= reg_wdata;
    if (byte_wr)            mem[byte_addr[AW-1:0]] <= byte_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q     <= '0;
      byte_rdata <= '0;
      reg_rdata  <= '0;
      bit_rdata  <= 1'b0;
    end else begin
      bank_q <= bank_sel[BW-1:0];
      if (byte_rd) byte_rdata <= mem[byte_addr[AW-1:0]];
      if (reg_rd)  reg_rdata  <= mem[reg_idx];
      if (bit_rd)  bit_rdata  <= bit_old[bit_addr[2:0]];
    end
  end
endmodule

// File: rtl/bitram_chk.sv
module bitram_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] bank_sel,
  input logic       byte_rd,
  input logic       byte_wr,
  input logic [6:0] byte_addr,
  input logic [7:0] byte_wdata,
  input logic [7:0] byte_rdata,
  input logic       reg_rd,
  input logic [2:0] reg_num,
  input logic [7:0] reg_rdata,
  input logic       bit_rd,
  input logic       bit_set,
  input logic       bit_clr,
  input logic [7:0] bit_addr,
  input logic       bit_rdata,
  input logic [7:0] sfr_addr,
  input logic [7:0] sfr_rdata,
  input logic       sfr_wr,
  input logic [7:0] sfr_wdata
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;

  p_reg_alias_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && reg_rd && byte_rd && byte_addr == 7'({$past(bank_sel), reg_num}))
    |=> reg_rdata == byte_rdata);

  p_bit_alias_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_rd && !bit_addr[7] && byte_rd && byte_addr == 7'(7'h20 + 7'(bit_addr[6:3])))
    |=> bit_rdata == byte_rdata[$past(bit_addr[2:0])]);

  p_sfr_onebit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_wr |-> $countones(sfr_wdata ^ sfr_rdata) <= 1);

  p_sfr_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bit_set || bit_clr) || !bit_addr[7]) |-> !sfr_wr);

  p_sfr_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_wr |-> sfr_addr[2:0] == 3'b000);

  p_byte_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && byte_rd && $past(byte_wr) && $past(byte_addr) == byte_addr)
    |=> byte_rdata == $past(byte_wdata, 2));
endmodule

bind bitram bitram_chk u_chk (.*);

// File: tb/bitram_bench.sv
module bitram_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] bank_sel = '0;
  logic byte_rd = 0, byte_wr = 0, reg_rd = 0, reg_wr = 0;
  logic bit_rd = 0, bit_set = 0, bit_clr = 0;
  logic [6:0] byte_addr = '0;
  logic [7:0] byte_wdata = '0, reg_wdata = '0, bit_addr = '0;
  logic [2:0] reg_num = '0;
  logic [7:0] byte_rdata, reg_rdata, sfr_addr, sfr_rdata, sfr_wdata;
  logic bit_rdata, sfr_wr;

  logic [7:0] exp_ram [128];
  logic [7:0] exp_sfr [16];
  logic [7:0] sfr_m   [16];
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  bitram u_bitram (.*);

  assign sfr_rdata = sfr_m[sfr_addr[6:3]];
  always @(posedge clk) if (sfr_wr) sfr_m[sfr_addr[6:3]] <= sfr_wdata;

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 37 + 5);
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic rd_byte(input logic [6:0] a, input string tag);
    byte_rd = 1; byte_addr = a; step(); byte_rd = 0;
    chk(tag, byte_rdata, exp_ram[a]);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #4000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      sfr_m[i] = 8'(i * 29 + 3);
      exp_sfr[i] = 8'(i * 29 + 3);
    end
    repeat (3) step();
    chk("R3 byte_rdata at reset", byte_rdata, 8'h00);
    chk("R3 reg_rdata at reset", reg_rdata, 8'h00);
    chk("R3 bit_rdata at reset", {7'd0, bit_rdata}, 8'h00);
    rst_n = 1; step();

    for (int i = 0; i < 128; i++) begin
      byte_wr = 1; byte_addr = 7'(i); byte_wdata = pat(i); step();
      exp_ram[i] = pat(i);
    end
    byte_wr = 0;
    for (int i = 0; i < 128; i++) rd_byte(7'(i), "R1 byte readback");

    byte_rd = 1; byte_wr = 1; byte_addr = 7'h05; byte_wdata = 8'hA5; step();
    byte_wr = 0;
    chk("R1 read before write", byte_rdata, exp_ram[5]);
    exp_ram[5] = 8'hA5;
    step(); byte_rd = 0;
    chk("R1 read after write", byte_rdata, 8'hA5);
    byte_addr = 7'h06; step();
    chk("R1 hold without read", byte_rdata, 8'hA5);

    for (int b = 0; b < 4; b++) begin
      bank_sel = 2'(b); step();
      for (int r = 0; r < 8; r++) begin
        reg_rd = 1; reg_num = 3'(r); step(); reg_rd = 0;
        chk("R2 bank register read", reg_rdata, exp_ram[b * 8 + r]);
        reg_wr = 1; reg_wdata = 8'(8'h40 + b * 8 + r); step(); reg_wr = 0;
        exp_ram[b * 8 + r] = 8'(8'h40 + b * 8 + r);
      end
    end
    for (int i = 0; i < 32; i++) rd_byte(7'(i), "R2 register write lands in bank");

    bank_sel = 2'd0; step();
    bank_sel = 2'd3; reg_rd = 1; reg_num = 3'd1; step(); reg_rd = 0;
    chk("R2 bank sampled one clock late", reg_rdata, exp_ram[1]);
    step();
    reg_rd = 1; step(); reg_rd = 0;
    chk("R2 new bank after one clock", reg_rdata, exp_ram[25]);

    for (int a = 0; a < 128; a++) begin
      bit_rd = 1; bit_addr = 8'(a); step(); bit_rd = 0;
      chk("R4 RAM bit read", {7'd0, bit_rdata}, {7'd0, exp_ram[32 + a / 8][a % 8]});
    end

    for (int a = 0; a < 128; a++) begin
      bit_addr = 8'(a);
      bit_set = (a % 3 != 0) || (a % 5 == 0);
      bit_clr = (a % 3 == 0);
      #1;
      chk("R6 no sfr_wr for RAM bit", {7'd0, sfr_wr}, 8'h00);
      step();
      exp_ram[32 + a / 8][a % 8] = bit_set;
      bit_set = 0; bit_clr = 0;
      rd_byte(7'(32 + a / 8), "R5 bit op result, set wins on both");
    end
    for (int i = 0; i < 128; i++) rd_byte(7'(i), "R5 untouched bits and bytes");

    for (int a = 128; a < 256; a++) begin
      bit_rd = 1; bit_addr = 8'(a); #1;
      chk("R6 sfr_addr", sfr_addr, 8'(a & 8'hF8));
      chk("R6 sfr_wr idle on read", {7'd0, sfr_wr}, 8'h00);
      step(); bit_rd = 0;
      chk("R7 SFR bit read", {7'd0, bit_rdata}, {7'd0, exp_sfr[(a / 8) % 16][a % 8]});
      bit_set = (a % 2 == 0); bit_clr = (a % 2 != 0); #1;
      begin
        logic [7:0] e;
        e = exp_sfr[(a / 8) % 16];
        e[a % 8] = bit_set;
        chk("R6 sfr_wr on bit op", {7'd0, sfr_wr}, 8'h01);
        chk("R6 sfr_wdata", sfr_wdata, e);
        exp_sfr[(a / 8) % 16] = e;
      end
      step(); bit_set = 0; bit_clr = 0;
    end
    for (int i = 0; i < 128; i++) rd_byte(7'(i), "R6 RAM untouched by SFR bit ops");

    bank_sel = 2'd1; step();
    byte_wr = 1; byte_addr = 7'h0A; byte_wdata = 8'h3C;
    reg_wr = 1; reg_num = 3'd2; reg_wdata = 8'h99; step();
    byte_wr = 0; reg_wr = 0; exp_ram[10] = 8'h3C;
    rd_byte(7'h0A, "R8 byte beats register");
    byte_wr = 1; byte_addr = 7'h23; byte_wdata = 8'h00;
    bit_set = 1; bit_addr = 8'h1F; step();
    byte_wr = 0; bit_set = 0; exp_ram[35] = 8'h00;
    rd_byte(7'h23, "R8 byte beats bit");
    byte_wr = 1; byte_addr = 7'h30; byte_wdata = 8'h77;
    reg_wr = 1; reg_num = 3'd3; reg_wdata = 8'h55;
    bit_clr = 1; bit_addr = 8'h21; step();
    byte_wr = 0; reg_wr = 0; bit_clr = 0;
    exp_ram[48] = 8'h77; exp_ram[11] = 8'h55; exp_ram[36][1] = 1'b0;
    rd_byte(7'h30, "R8 parallel byte write");
    rd_byte(7'h0B, "R8 parallel register write");
    rd_byte(7'h24, "R8 parallel bit write");

    bank_sel = 2'd2; rst_n = 0; step(); step();
    chk("R3 byte_rdata cleared", byte_rdata, 8'h00);
    chk("R3 reg_rdata cleared", reg_rdata, 8'h00);
    rst_n = 1; reg_rd = 1; reg_num = 3'd4; step(); reg_rd = 0;
    chk("R3 bank 0 after reset", reg_rdata, exp_ram[4]);
    for (int i = 0; i < 128; i++) rd_byte(7'(i), "R3 RAM kept through reset");

    finish_run();
  end
endmodule